// File: doc/BRIEF.md
# Power Stage Fault Protection Controller

This block is the digital supervisor of a multi-half-bridge class-D output stage. It watches a set of protection flags: an overcurrent flag for each half-bridge, one shared undervoltage flag, and two shared thermal comparator flags (warning and error). From these flags it decides whether the output transistors may switch or must be held in the high-impedance state. The analog detectors are outside the block and reach it as plain digital levels. Every flag passes through a two-flop synchronizer before the block uses it.

An active-low hold input acts as a mute. When hold falls, the fault latch clears. A two-bit response-mode selector picks the reaction to a fault: latch until hold is toggled, or recover by itself after a fixed number of PWM input periods. A separate test input turns off all protection responses. Two active-low status outputs, each standing in for an open-drain pin, report one of four chip states.

Top module: `pstg_guard`

## Requirements
- R1: In a protected mode, any single overcurrent bit, the undervoltage flag or the thermal-error flag sets the fault latch. Within 6 clock cycles every bit of `out_en` is then 0. All bits of `out_en` always hold the same value.
- R2: While `hold_n` is low, `out_en` is all zeros and `sd_n` is 1, whatever the fault state.
- R3: In latching mode (`resp_mode` = 2'b01), a tripped stage stays in high-impedance after the fault is removed, as long as `hold_n` stays high. A falling edge of `hold_n` clears the latch. Switching resumes when `hold_n` returns high. A fault that is still present while `hold_n` is low sets the latch again.
- R4: The reserved codes `resp_mode` = 2'b00 and 2'b11 behave as latching mode. PWM periods never release the latch in these codes.
- R5: In autorecovery mode (`resp_mode` = 2'b10), a tripped stage returns to switching after `AR_WAIT` rising edges of `pwm_in`. Only edges that arrive while no fault is active count. A fault that persists keeps the stage in high-impedance for any number of edges.
- R6: The pair {`otw_n`, `sd_n`} encodes the chip state. 2'b00 means the thermal error flag is active and the stage is tripped. 2'b01 means thermal warning only. 2'b10 means tripped with no thermal flag (overcurrent or undervoltage). 2'b11 means normal operation.
- R7: `otw_n` is 0 while the thermal warning or the thermal error flag is active, and 1 otherwise. The warning flag alone never trips the stage.
- R8: While `prot_off` is 1, no fault flag trips the stage, and `out_en` follows `hold_n` alone.
- R9: While `por_n` is low and right after it rises (with `hold_n` low), `out_en` is all zeros, `sd_n` is 1 and `otw_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| hold_n | input | 1 | Mute and fault-clear input, active low |
| resp_mode | input | 2 | Response mode: 01 latch, 10 autorecover, 00/11 latch |
| prot_off | input | 1 | Test input, 1 disables all protection responses |
| pwm_in | input | 1 | PWM input used as the autorecovery timebase |
| oc_flag | input | NUM_HB | Overcurrent flag for each half-bridge |
| uv_flag | input | 1 | Shared undervoltage flag |
| tw_flag | input | 1 | Shared thermal warning flag |
| te_flag | input | 1 | Shared thermal error flag |
| out_en | output | NUM_HB | Per half-bridge switching enable, 0 = high-impedance |
| sd_n | output | 1 | Shutdown status, low when tripped and hold_n is high |
| otw_n | output | 1 | Thermal warning status, low when hot |

## Verification
Each fault source is swept one at a time in latching mode. The resulting status pair separates the thermal-error trip (00) from the overcurrent or undervoltage trip (10), and it shows that every source drives every half-bridge to high-impedance. The thermal warning on its own is applied to show that it changes only `otw_n`.

Three hold sequences are compared: a clean toggle, a hold held low while the fault stays present, and a hold held low with no fault. Together they separate a falling-edge clear from a level clear and show that hold mutes the outputs.

In autorecovery mode, exactly `AR_WAIT`-1 and then `AR_WAIT` clean PWM edges are applied, which pins down the recovery count. A long edge train under a persisting fault, and the same train in the reserved codes, shows that the counter runs only when it should.

// File: rtl/pstg_pkg.sv
package pstg_pkg;

   typedef enum logic {
      RESP_LATCH = 1'b0,
      RESP_AUTO  = 1'b1
   } resp_e;

   localparam logic [1:0] MSEL_LATCH = 2'b01;
   localparam logic [1:0] MSEL_AUTO  = 2'b10;

   // Reserved selector codes fall back to the latching response.
   function automatic resp_e decode_resp(input logic [1:0] msel);
      return (msel == MSEL_AUTO) ? RESP_AUTO : RESP_LATCH;
   endfunction

endpackage

// File: rtl/pstg_sync.sv
module pstg_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pstg_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pstg_ar_timer.sv
module pstg_ar_timer #(
   parameter int AR_WAIT = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   input  logic tick,
   output logic done
);
   localparam int CW = $clog2(AR_WAIT + 1);
   localparam logic [CW-1:0] LAST = CW'(AR_WAIT - 1);

   if (AR_WAIT < 2) begin : g_bad_wait
      $error("pstg_ar_timer: AR_WAIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clear || !run)  cnt <= '0;
      else if (tick)           cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign done = run && !clear && tick && (cnt == LAST);
endmodule

// File: rtl/pstg_guard.sv
module pstg_guard
   import pstg_pkg::*;
#(
   parameter int NUM_HB      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int AR_WAIT     = 65536
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              hold_n,
   input  logic [1:0]        resp_mode,
   input  logic              prot_off,
   input  logic              pwm_in,
   input  logic [NUM_HB-1:0] oc_flag,
   input  logic              uv_flag,
   input  logic              tw_flag,
   input  logic              te_flag,
   output logic [NUM_HB-1:0] out_en,
   output logic              sd_n,
   output logic              otw_n
);
   localparam int SHARED_W = 5;

   if (NUM_HB < 1) begin : g_bad_hb
      $error("pstg_guard: NUM_HB must be at least 1");
   end

   // Per half-bridge overcurrent synchronizers
   logic [NUM_HB-1:0] oc_s;
   for (genvar b = 0; b < NUM_HB; b++) begin : g_hb
      pstg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oc_sync (
         .clk   (clk),
         .rst_n (por_n),
         .d     (oc_flag[b]),
         .q     (oc_s[b])
      );
   end

   // Shared flags, hold and timebase
   logic [SHARED_W-1:0] sh_s;
   logic uv_s, tw_s, te_s, hold_s, pwm_s;
   pstg_sync #(.W(SHARED_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sh_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     ({uv_flag, tw_flag, te_flag, hold_n, pwm_in}),
      .q     (sh_s)
   );
   assign {uv_s, tw_s, te_s, hold_s, pwm_s} = sh_s;

   // Edge detection on hold and PWM
   logic hold_d, pwm_d;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hold_d <= 1'b0;
         pwm_d  <= 1'b0;
      end else begin
         hold_d <= hold_s;
         pwm_d  <= pwm_s;
      end
   end

   logic hold_fall, pwm_rise, fault_now, latch_mode, ar_done, trip_q;
   resp_e resp;

   assign hold_fall  = hold_d & ~hold_s;
   assign pwm_rise   = pwm_s & ~pwm_d;
   assign fault_now  = ~prot_off & ((|oc_s) | uv_s | te_s);
   assign resp       = decode_resp(resp_mode);
   assign latch_mode = (resp == RESP_LATCH);

   pstg_ar_timer #(.AR_WAIT(AR_WAIT)) u_ar (
      .clk   (clk),
      .rst_n (por_n),
      .run   (trip_q & ~latch_mode),
      .clear (fault_now | hold_fall),
      .tick  (pwm_rise),
      .done  (ar_done)
   );

   // Fault latch: cleared on the hold falling edge, set by any fault
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         trip_q <= 1'b0;
      else if (hold_fall) trip_q <= 1'b0;
      else if (fault_now) trip_q <= 1'b1;
      else if (ar_done)   trip_q <= 1'b0;
   end

   // Registered outputs
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         out_en <= '0;
         sd_n   <= 1'b1;
         otw_n  <= 1'b1;
      end else begin
         out_en <= {NUM_HB{hold_s & ~trip_q}};
         sd_n   <= ~hold_s | ~trip_q;
         otw_n  <= ~(tw_s | te_s);
      end
   end
endmodule

// File: rtl/pstg_guard_chk.sv
module pstg_guard_chk #(
   parameter int NUM_HB = 4
) (
   input logic              clk,
   input logic              por_n,
   input logic              hold_s,
   input logic              hold_fall,
   input logic              fault_now,
   input logic              latch_mode,
   input logic              prot_off,
   input logic              ar_done,
   input logic              trip_q,
   input logic [NUM_HB-1:0] out_en,
   input logic              sd_n
);
   AST_FAULT_TRIPS: assert property (@(posedge clk) disable iff (!por_n)
      (fault_now && !hold_fall) |=> trip_q); // R1

   AST_EN_UNIFORM: assert property (@(posedge clk) disable iff (!por_n)
      (out_en == '0) || (out_en == '1)); // R1

   AST_HOLD_MUTES: assert property (@(posedge clk) disable iff (!por_n)
      $past(!hold_s) |-> (sd_n && out_en == '0)); // R2

   AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
      $past(trip_q && latch_mode && !hold_fall) |-> trip_q); // R3

   AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
      $fell(trip_q) |-> $past(hold_fall || ar_done)); // R5

   AST_TEST_NO_TRIP: assert property (@(posedge clk) disable iff (!por_n)
      $past(!trip_q && prot_off) |-> !trip_q); // R8
endmodule

bind pstg_guard pstg_guard_chk #(.NUM_HB(NUM_HB)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .hold_s     (hold_s),
   .hold_fall  (hold_fall),
   .fault_now  (fault_now),
   .latch_mode (latch_mode),
   .prot_off   (prot_off),
   .ar_done    (ar_done),
   .trip_q     (trip_q),
   .out_en     (out_en),
   .sd_n       (sd_n)
);

// File: tb/pstg_guard_test.sv
module pstg_guard_test;
   localparam int NHB = 4;
   localparam int ARW = 8;
   localparam logic [NHB-1:0] ALL = '1;

   logic           clk = 1'b0;
   logic           por_n = 1'b0;
   logic           hold_n = 1'b0;
   logic [1:0]     resp_mode = 2'b01;
   logic           prot_off = 1'b0;
   logic           pwm_in = 1'b0;
   logic [NHB-1:0] oc_flag = '0;
   logic           uv_flag = 1'b0, tw_flag = 1'b0, te_flag = 1'b0;
   logic [NHB-1:0] out_en;
   logic           sd_n, otw_n;

   int total = 0;
   int fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pstg_guard #(.NUM_HB(NHB), .SYNC_STAGES(2), .AR_WAIT(ARW)) uut (
      .clk(clk), .por_n(por_n), .hold_n(hold_n), .resp_mode(resp_mode),
      .prot_off(prot_off), .pwm_in(pwm_in), .oc_flag(oc_flag),
      .uv_flag(uv_flag), .tw_flag(tw_flag), .te_flag(te_flag),
      .out_en(out_en), .sd_n(sd_n), .otw_n(otw_n)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         pwm_in = 1'b1; step(4);
         pwm_in = 1'b0; step(4);
      end
   endtask

   // source k: 0..NHB-1 overcurrent, NHB undervoltage, NHB+1 thermal error
   task automatic set_src(input int k, input logic v);
      if (k < NHB) oc_flag[k] = v;
      else if (k == NHB) uv_flag = v;
      else te_flag = v;
   endtask

   task automatic toggle_hold();
      hold_n = 1'b0; step(6);
      hold_n = 1'b1; step(6);
   endtask

   initial begin
      step(1);
      chk("R9 out_en in por", 32'(out_en), 0);
      chk("R9 sd_n in por", 32'(sd_n), 1);
      chk("R9 otw_n in por", 32'(otw_n), 1);
      step(3); por_n = 1'b1; step(2);
      chk("R9 out_en after por", 32'(out_en), 0);
      chk("R9 status after por", 32'({otw_n, sd_n}), 2'b11);

      hold_n = 1'b1; step(6);
      chk("R6 normal out_en", 32'(out_en), 32'(ALL));
      chk("R6 normal status", 32'({otw_n, sd_n}), 2'b11);

      hold_n = 1'b0; step(6);
      chk("R2 mute out_en", 32'(out_en), 0);
      chk("R2 mute sd_n", 32'(sd_n), 1);
      hold_n = 1'b1; step(6);

      // R1/R3/R6: sweep every fault source in latching mode
      for (int k = 0; k < NHB + 2; k++) begin
         logic [1:0] st_exp;
         st_exp = (k == NHB + 1) ? 2'b00 : 2'b10;
         set_src(k, 1'b1); step(6);
         chk("R1 trip out_en", 32'(out_en), 0);
         chk("R6 trip status", 32'({otw_n, sd_n}), 32'(st_exp));
         set_src(k, 1'b0); step(6);
         chk("R3 latched out_en", 32'(out_en), 0);
         chk("R3 latched status", 32'({otw_n, sd_n}), 2'b10);
         hold_n = 1'b0; step(6);
         chk("R2 sd_n forced high", 32'(sd_n), 1);
         chk("R2 out_en muted", 32'(out_en), 0);
         hold_n = 1'b1; step(6);
         chk("R3 resumed out_en", 32'(out_en), 32'(ALL));
         chk("R3 resumed sd_n", 32'(sd_n), 1);
      end

      // R7: warning alone
      tw_flag = 1'b1; step(6);
      chk("R7 warn out_en", 32'(out_en), 32'(ALL));
      chk("R6 warn status", 32'({otw_n, sd_n}), 2'b01);
      tw_flag = 1'b0; step(6);
      chk("R7 warn released", 32'(otw_n), 1);

      // R3: fault still present while hold low re-trips
      uv_flag = 1'b1; step(6);
      hold_n = 1'b0; step(6);
      uv_flag = 1'b0; step(6);
      hold_n = 1'b1; step(6);
      chk("R3 re-trip while held out_en", 32'(out_en), 0);
      chk("R3 re-trip while held sd_n", 32'(sd_n), 0);
      toggle_hold();
      chk("R3 clean toggle out_en", 32'(out_en), 32'(ALL));

      // R4: reserved codes latch
      for (int c = 0; c < 2; c++) begin
         resp_mode = (c == 0) ? 2'b00 : 2'b11;
         oc_flag[0] = 1'b1; step(6);
         oc_flag[0] = 1'b0; step(6);
         pulses(2 * ARW); step(6);
         chk("R4 reserved stays tripped", 32'(out_en), 0);
         toggle_hold();
         chk("R4 reserved hold recovers", 32'(out_en), 32'(ALL));
      end

      // R5: autorecovery
      resp_mode = 2'b10;
      uv_flag = 1'b1; step(6);
      pulses(2 * ARW); step(6);
      chk("R5 persisting fault holds", 32'(out_en), 0);
      uv_flag = 1'b0; step(6);
      pulses(ARW - 1); step(6);
      chk("R5 one edge short", 32'(out_en), 0);
      chk("R5 one edge short sd_n", 32'(sd_n), 0);
      pulses(1); step(6);
      chk("R5 recovered out_en", 32'(out_en), 32'(ALL));
      chk("R5 recovered status", 32'({otw_n, sd_n}), 2'b11);

      // R8: protection disabled
      resp_mode = 2'b01;
      prot_off = 1'b1;
      oc_flag[NHB-1] = 1'b1; te_flag = 1'b1; step(6);
      chk("R8 no trip out_en", 32'(out_en), 32'(ALL));
      chk("R8 no trip sd_n", 32'(sd_n), 1);
      chk("R7 te drives otw_n", 32'(otw_n), 0);
      oc_flag = '0; te_flag = 1'b0; step(6);
      prot_off = 1'b0; step(6);
      chk("R8 still running", 32'(out_en), 32'(ALL));

      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule